// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block sits next to a processor core and decides which of sixteen prioritized event lines the core should service next. Level 0 is the most urgent and level 15 the least. Levels 0 to 6 have fixed roles. In order they are debug/emulation entry, reset, non-maskable interrupt, synchronous exception, a reserved slot, hardware error and core timer. Levels 7 to 15 are general-purpose interrupt inputs.

An event line that is high at a clock edge is captured into a pending register. A per-level enable register gates which pending events may be serviced. When a pending, enabled level outranks everything currently in service, the block issues a one-cycle one-hot grant. At that moment the pending bit clears and the level joins the in-service set. A return-from-event pulse retires the most urgent level in service. Both registers are 32 bits wide and are reached through a small register port. A privilege input gates that port: reads return zero and writes are dropped unless the privilege input is high. The write data lane carries only the 16 implemented bits.

Nesting is tracked by a three-state machine, with the in-service vector held beside it:
- IDLE: nothing is in service.
- SERVE: exactly one level is in service.
- NEST: two or more levels are in service.

The transitions are:
- GRANT_FIRST: IDLE to SERVE.
- PREEMPT: SERVE to NEST, when a grant arrives with no return pulse.
- RETIRE_LAST: SERVE to IDLE, when a return pulse arrives with no grant.
- UNWIND: NEST to SERVE, when a return pulse arrives while two levels are in service and no grant is made.
- SWAP: SERVE to SERVE, when a return pulse and a grant arrive together.

In IDLE any pending enabled level may be granted. In SERVE and NEST the candidate must be numerically below the lowest in-service level.

Top module: `evt_core_ctrl`

## Requirements
- R1: After reset the pending register, the stored enable bits and the in-service vector are all zero, and no grant is issued; the enable register then reads 0x0000_0007.
- R2: An event line high at a clock edge sets the pending bit of the same index at that edge. Level 4 never becomes pending and always reads 0.
- R3: A pending bit clears at the edge where its level is granted, unless its event line is high at that edge.
- R4: The candidate is the lowest-numbered bit of (pending AND effective enable). Bits 0, 1 and 2 are always enabled. An enable bit of 0 blocks service but leaves the bit pending.
- R5: A grant appears on `grant_valid` with a one-hot `grant_lvl` (bit index = level) for the cycle after the edge at which the candidate was already pending. At that same edge the level's bit is set in `active_lvl`.
- R6: A candidate is granted only if no level is in service, or its number is strictly lower than every in-service level. Otherwise it stays pending.
- R7: A return pulse clears the lowest-numbered set bit of `active_lvl` at the next edge. With nothing in service it has no effect.
- R8: With `supv_mode` high, `reg_sel`=0 reads the pending register and `reg_sel`=1 reads the enable register, with bits 31:16 reading 0. With `supv_mode` low, reads return 0.
- R9: An enable write (`reg_sel`=1) with `supv_mode` high loads bits 3 and 5 to 15 from `reg_wdata`. Bits 0 to 2 read 1 and bit 4 reads 0. An enable write with `supv_mode` low is ignored.
- R10: A pending write (`reg_sel`=0) with `supv_mode` high loads each bit whose effective enable is 0 from `reg_wdata`, so a pending event can be cancelled by writing 0. Enabled bits are untouched, and a pending write with `supv_mode` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_req | input | 16 | Event lines, bit index = level |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 pending, 1 enable |
| reg_wdata | input | 16 | Write data for the implemented bits |
| supv_mode | input | 1 | Privilege qualifier for register access |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| rfe_pulse | input | 1 | Return from the current event |
| grant_valid | output | 1 | Grant strobe |
| grant_lvl | output | 16 | One-hot granted level |
| active_lvl | output | 16 | Levels currently in service |

## Verification
Capture, register writes, grants and retirements all act at the single edge that follows the cycle in which their inputs are presented. A pulsed event therefore becomes visible as pending one edge after it is driven and, if it qualifies, as a grant one edge later. A mask or return pulse that unblocks a waiting event likewise produces its grant one edge later. Read data is combinational, so it reflects the state updated by the preceding edge. The bench drives every input on a falling edge. It advances its own cycle model at the rising edge and compares grant, in-service vector and read data on the following falling edge. Directed sequences add literal expectations at exactly those points.

// File: rtl/evt_ctrl_pkg.sv
package evt_ctrl_pkg;

    // register select encoding on the access port
    localparam logic SEL_PEND = 1'b0;
    localparam logic SEL_ENAB = 1'b1;

    // nesting depth states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_NEST  = 2'd2
    } nest_st_e;

    // vector with the lowest n bits set
    function automatic logic [31:0] low_ones(input int n);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < n) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  first
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
        // isolate the lowest set bit
        first = req & (~req + N'(1));
    end

endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank
    import evt_ctrl_pkg::*;
#(
    parameter int N        = 16,
    parameter int DW       = 32,
    parameter int N_FORCED = 3,
    parameter int RSV      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_in,
    input  logic [N-1:0]  accept,
    input  logic          reg_we,
    input  logic          reg_sel,
    input  logic [N-1:0]  wdata,
    input  logic          supv,
    output logic [N-1:0]  latch_q,
    output logic [N-1:0]  mask_eff,
    output logic [DW-1:0] rdata
);

    localparam int          PAD       = DW - N;
    localparam logic [N-1:0] FORCED_V = N'(low_ones(N_FORCED));
    localparam logic [N-1:0] RSV_V    = N'(1) << RSV;
    localparam logic [N-1:0] CAN_PEND = ~RSV_V;
    localparam logic [N-1:0] EN_STORE = ~(FORCED_V | RSV_V);

    logic [N-1:0] mask_r;
    logic [N-1:0] latch_d;
    logic [N-1:0] sw_view;
    logic [N-1:0] sel_view;
    logic         wr_pend;
    logic         wr_enab;

    assign wr_pend  = reg_we & supv & (reg_sel == SEL_PEND);
    assign wr_enab  = reg_we & supv & (reg_sel == SEL_ENAB);
    assign mask_eff = mask_r | FORCED_V;

    always_comb begin
        // software write reaches only bits that are not enabled
        sw_view  = wr_pend ? ((wdata & ~mask_eff) | (latch_q & mask_eff)) : latch_q;
        // capture beats accept-clear, which beats software write
        latch_d  = (evt_in | (~accept & sw_view)) & CAN_PEND;
        sel_view = (reg_sel == SEL_ENAB) ? mask_eff : latch_q;
        rdata    = supv ? {{PAD{1'b0}}, sel_view} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            mask_r  <= '0;
        end else begin
            latch_q <= latch_d;
            if (wr_enab) mask_r <= wdata & EN_STORE;
        end
    end

    // R2: a captured line is pending one edge later
    a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_in & CAN_PEND) != '0) |=> ((latch_q & $past(evt_in & CAN_PEND)) == $past(evt_in & CAN_PEND)));

    // R3: a granted level leaves the pending set unless re-raised
    a_r3_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (accept != '0) |=> ((latch_q & $past(accept & ~evt_in)) == '0));

    // R9: enable writes without privilege leave the register alone
    a_r9_user_enab_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !supv) |=> $stable(mask_r));

    // R10: unprivileged access never alters pending bits except by capture or accept
    a_r10_user_pend_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !supv && evt_in == '0 && accept == '0) |=> $stable(latch_q));

endmodule

// File: rtl/evt_nest_track.sv
module evt_nest_track
    import evt_ctrl_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    input  logic         rfe,
    output logic [N-1:0] accept,
    output logic         grant_valid,
    output logic [N-1:0] grant_vec,
    output logic [N-1:0] active_q
);

    nest_st_e      state_q;
    nest_st_e      state_d;
    logic          p_hit;
    logic [IW-1:0] p_idx;
    logic [N-1:0]  p_first;
    logic          a_hit;
    logic [IW-1:0] a_idx;
    logic [N-1:0]  a_first;
    logic          take;
    logic          two_left;
    logic [N-1:0]  rfe_clr;
    logic [N-1:0]  active_d;

    evt_prio_pick #(.N(N), .IW(IW)) u_pend_pick (
        .req   (pend),
        .hit   (p_hit),
        .idx   (p_idx),
        .first (p_first)
    );

    evt_prio_pick #(.N(N), .IW(IW)) u_act_pick (
        .req   (active_q),
        .hit   (a_hit),
        .idx   (a_idx),
        .first (a_first)
    );

    assign two_left = ($countones(active_q) == 2);

    always_comb begin
        take     = p_hit && ((state_q == ST_IDLE) || (p_idx < a_idx));
        accept   = take ? p_first : '0;
        rfe_clr  = (rfe && a_hit) ? a_first : '0;
        active_d = (active_q & ~rfe_clr) | accept;
    end

    // next-state: GRANT_FIRST, PREEMPT, RETIRE_LAST, UNWIND, SWAP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_d = ST_SERVE;
            end
            ST_SERVE: begin
                if (take && !rfe)      state_d = ST_NEST;
                else if (rfe && !take) state_d = ST_IDLE;
                else                   state_d = ST_SERVE;
            end
            ST_NEST: begin
                if (rfe && !take && two_left) state_d = ST_SERVE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q    <= '0;
            grant_valid <= 1'b0;
            grant_vec   <= '0;
        end else begin
            active_q    <= active_d;
            grant_valid <= take;
            grant_vec   <= accept;
        end
    end

    // R5: grant vector is one-hot with the strobe and empty without it
    a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($countones(grant_vec) == 1));
    a_r5_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant_vec == '0));
    a_r5_grant_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((active_q & grant_vec) == grant_vec));

    // R6: every level in service before a grant ranks strictly below it
    a_r6_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (($past(active_q) & ((grant_vec << 1) - N'(1))) == '0));

    // R7: a return with no concurrent grant drops exactly one level
    a_r7_rfe_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && active_q != '0 && !take) |=> ($countones(active_q) == $past($countones(active_q)) - 1));

    // R7: depth state agrees with the in-service vector
    a_r7_idle_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) == (active_q == '0));

endmodule

// File: rtl/evt_core_ctrl.sv
module evt_core_ctrl #(
    parameter int N_LVL    = 16,
    parameter int REG_W    = 32,
    parameter int N_FORCED = 3,
    parameter int RSV_LVL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] evt_req,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [N_LVL-1:0] reg_wdata,
    input  logic             supv_mode,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             rfe_pulse,
    output logic             grant_valid,
    output logic [N_LVL-1:0] grant_lvl,
    output logic [N_LVL-1:0] active_lvl
);

    localparam int IW = $clog2(N_LVL);

    logic [N_LVL-1:0] pend_q;
    logic [N_LVL-1:0] en_eff;
    logic [N_LVL-1:0] accept;
    logic [N_LVL-1:0] eligible;

    assign eligible = pend_q & en_eff;

    evt_latch_bank #(
        .N        (N_LVL),
        .DW       (REG_W),
        .N_FORCED (N_FORCED),
        .RSV      (RSV_LVL)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_req),
        .accept   (accept),
        .reg_we   (reg_we),
        .reg_sel  (reg_sel),
        .wdata    (reg_wdata),
        .supv     (supv_mode),
        .latch_q  (pend_q),
        .mask_eff (en_eff),
        .rdata    (reg_rdata)
    );

    evt_nest_track #(
        .N  (N_LVL),
        .IW (IW)
    ) u_nest (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (eligible),
        .rfe         (rfe_pulse),
        .accept      (accept),
        .grant_valid (grant_valid),
        .grant_vec   (grant_lvl),
        .active_q    (active_lvl)
    );

    // R4: a granted level was pending and enabled in the cycle before
    a_r4_grant_was_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (($past(eligible) & grant_lvl) == grant_lvl));

    // R8: unprivileged reads see nothing
    a_r8_read_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        !supv_mode |-> (reg_rdata == '0));

endmodule

// File: tb/sim_evt_core_ctrl.sv
`timescale 1ns/1ps
module sim_evt_core_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_req = '0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        supv_mode = 1'b1;
    logic [31:0] reg_rdata;
    logic        rfe_pulse = 1'b0;
    logic        grant_valid;
    logic [15:0] grant_lvl;
    logic [15:0] active_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model of the state
    logic [15:0] m_pend = '0;
    logic [15:0] m_en   = '0;
    logic [15:0] m_act  = '0;
    logic        m_gv   = 1'b0;
    logic [15:0] m_gl   = '0;

    always #10 clk = ~clk;

    evt_core_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_req     (evt_req),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .supv_mode   (supv_mode),
        .reg_rdata   (reg_rdata),
        .rfe_pulse   (rfe_pulse),
        .grant_valid (grant_valid),
        .grant_lvl   (grant_lvl),
        .active_lvl  (active_lvl)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] en_view(input logic [15:0] en);
        return (en & 16'hFFE8) | 16'h0007;
    endfunction

    function automatic int lowest(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return 16;
    endfunction

    function automatic logic [31:0] exp_read();
        if (!supv_mode) return 32'h0;
        return {16'h0, reg_sel ? en_view(m_en) : m_pend};
    endfunction

    // one rising edge of the model, from the requirements
    task automatic model_edge();
        logic [15:0] eff;
        logic [15:0] acc;
        logic [15:0] clr;
        logic [15:0] npend;
        int          pi;
        int          ai;
        eff = m_pend & en_view(m_en);
        pi  = lowest(eff);
        ai  = lowest(m_act);
        acc = (pi < 16 && pi < ai) ? (16'h1 << pi) : 16'h0;
        clr = (rfe_pulse && ai < 16) ? (16'h1 << ai) : 16'h0;
        npend = m_pend;
        if (reg_we && supv_mode && !reg_sel)
            npend = (reg_wdata & ~en_view(m_en)) | (m_pend & en_view(m_en));
        npend = (evt_req | (npend & ~acc)) & 16'hFFEF;
        if (reg_we && supv_mode && reg_sel) m_en = reg_wdata & 16'hFFE8;
        m_pend = npend;
        m_act  = (m_act & ~clr) | acc;
        m_gv   = (acc != 16'h0);
        m_gl   = acc;
    endtask

    task automatic step(input logic [15:0] e, input logic we, input logic sel,
                        input logic [15:0] wd, input logic sv, input logic rf, input string tag);
        evt_req   = e;
        reg_we    = we;
        reg_sel   = sel;
        reg_wdata = wd;
        supv_mode = sv;
        rfe_pulse = rf;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " R5 grant_valid"}, {31'h0, grant_valid}, {31'h0, m_gv});
        check({tag, " R6 grant_lvl"}, {16'h0, grant_lvl}, {16'h0, m_gl});
        check({tag, " R7 active_lvl"}, {16'h0, active_lvl}, {16'h0, m_act});
        check({tag, " R8 reg_rdata"}, reg_rdata, exp_read());
    endtask

    task automatic idle(input int n, input logic sel, input string tag);
        for (int k = 0; k < n; k++) step(16'h0, 1'b0, sel, 16'h0, 1'b1, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int seed_v;
        seed_v = $urandom(32'h5EED1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_sel = 1'b0;
        #1;
        check("R1 pending after reset", reg_rdata, 32'h0);
        check("R1 in-service after reset", {16'h0, active_lvl}, 32'h0);
        check("R1 no grant after reset", {31'h0, grant_valid}, 32'h0);
        idle(1, 1'b1, "R1");
        check("R1 enable after reset", reg_rdata, 32'h0000_0007);

        // R9 enable writes
        step(16'h0, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0, "R9 user");
        idle(1, 1'b1, "R9");
        check("R9 user enable write ignored", reg_rdata, 32'h0000_0007);
        step(16'h0, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0, "R9 supv");
        idle(1, 1'b1, "R9");
        check("R9 supv enable write", reg_rdata, 32'h0000_FFEF);
        step(16'h0, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, "R9 clear");

        // R4 blocked event stays pending, R2 reserved level
        step(16'h0200, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R4 pulse");
        idle(2, 1'b0, "R4");
        check("R4 blocked level still pending", reg_rdata, 32'h0000_0200);
        check("R4 blocked level not served", {16'h0, active_lvl}, 32'h0);
        step(16'h0010, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R2 rsv");
        idle(1, 1'b0, "R2");
        check("R2 reserved level never pending", reg_rdata, 32'h0000_0200);

        // R10 cancel by write
        step(16'h0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, "R10 user");
        idle(1, 1'b0, "R10");
        check("R10 user pending write ignored", reg_rdata, 32'h0000_0200);
        step(16'h0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, "R10 supv");
        check("R10 cancel pending", reg_rdata, 32'h0);

        // R4/R5 enabling releases the grant one edge later, R3 clears pending
        step(16'h0200, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R4 again");
        step(16'h0, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0, "R4 enable");
        check("R5 no grant at enable edge", {31'h0, grant_valid}, 32'h0);
        idle(1, 1'b0, "R5");
        check("R5 grant strobe", {31'h0, grant_valid}, 32'h1);
        check("R5 grant level 9", {16'h0, grant_lvl}, 32'h0000_0200);
        check("R3 pending cleared on accept", reg_rdata, 32'h0);

        // R6 nesting
        step(16'h2000, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R6 low");
        idle(2, 1'b0, "R6");
        check("R6 lower priority waits", {16'h0, active_lvl}, 32'h0000_0200);
        check("R6 lower priority pending", reg_rdata, 32'h0000_2000);
        step(16'h0004, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R6 nmi");
        idle(1, 1'b0, "R6");
        check("R6 higher priority nests", {16'h0, active_lvl}, 32'h0000_0204);

        // R7 return from event
        step(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, "R7 ret1");
        check("R7 retire lowest level", {16'h0, active_lvl}, 32'h0000_0200);
        step(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, "R7 ret2");
        check("R7 retire last level", {16'h0, active_lvl}, 32'h0);
        idle(1, 1'b0, "R7");
        check("R7 waiting level granted", {16'h0, active_lvl}, 32'h0000_2000);
        step(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, "R7 ret3");
        step(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1, "R7 empty");
        check("R7 return with nothing active", {16'h0, active_lvl}, 32'h0);

        // R8 unprivileged read
        step(16'h0, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0, "R8");
        check("R8 unprivileged read zero", reg_rdata, 32'h0);

        // constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            logic [15:0] e;
            e = (($urandom % 6) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
            step(e, (($urandom % 7) == 0), $urandom % 2, 16'($urandom),
                 (($urandom % 4) != 0), (($urandom % 4) == 0), "random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule